// File: doc/BRIEF.md
# I2C Receive Acknowledge Engine

This block is the receive-side byte engine of an I2C controller working as master-receiver or slave-receiver. It takes one-cycle strobes that mark the rising and falling edges of SCL, samples SDA on each rising edge, and assembles bytes MSB first. For every byte it decides whether to pull SDA low during the acknowledge clock (ACK) or to leave it released (NACK). The surrounding controller owns arbitration, clock generation, address matching and the START/STOP waveforms.

The ACK/NACK decision is made at the rising SCL edge of the eighth data bit. A NACK can come from four sources:
- a one-shot software request;
- an unread previous byte, or disabled transfers, when acting as slave;
- a STOP request in repeat master mode;
- the down-counting byte counter, or a late STOP request, in non-repeat master mode.

When the byte being NACKed is the last byte of a master transfer, the block pulses a STOP request at the end of that acknowledge clock. Clearing the run bit aborts at once.

Control word bit positions (`ctrl_wdata`): bit 0 run, bit 1 master, bit 2 repeat mode, bit 3 STOP request, bit 4 transfer enable, bit 5 NACK request.

Top module: `rx_ack_engine`

## Requirements
- R1: Data bits are sampled from `sda_in` on `scl_rise` strobes, MSB first. On the edge that takes the eighth bit of an accepted byte, `rx_byte` is loaded, `byte_stb` pulses for one cycle and `rx_ready` is set. An `rx_rd` pulse clears `rx_ready`.
- R2: `sda_pull_en` goes high on the `scl_fall` strobe that follows the eighth bit, only for an ACKed byte. It goes low on the next `scl_fall`, which ends the acknowledge clock. It is low during all data bits and for NACKed bytes.
- R3: A NACK request (bit 5) written before the eighth-bit `scl_rise` NACKs that byte, and `nack_pend` clears on that edge. A request written after that edge leaves the current byte ACKed, stays pending, and NACKs the next byte.
- R4: In slave mode, a byte that completes while `rx_ready` is set and no read happens in that cycle is NACKed. It sets `rx_overrun`, gives no `byte_stb` and leaves `rx_byte` unchanged. In master mode the same case is still ACKed. `rx_rd` clears `rx_overrun`.
- R5: In slave mode with transfer enable (bit 4) clear, every byte is NACKed.
- R6: In repeat master mode (bits 1 and 2 set), bytes are ACKed indefinitely. With the STOP request set, the current byte is NACKed, `stop_gen` pulses on the `scl_fall` that ends its acknowledge clock, and the STOP request clears.
- R7: In non-repeat master mode, the byte counter decrements once per byte. With the STOP request set, the byte received while the counter holds 1 is NACKed and followed by a `stop_gen` pulse. All earlier bytes are ACKed. A loaded count of 0 stands for 2^CNT_W bytes.
- R8: In non-repeat master mode, a STOP request raised after the first byte of a transfer NACKs the byte in progress and produces `stop_gen` after it, whatever the counter holds.
- R9: A control write with run clear releases `sda_pull_en` and clears `rx_ready`, `rx_overrun` and the bit position at that clock edge. The next byte after re-enabling is received from its first bit.
- R10: After reset, `sda_pull_en`, `byte_stb`, `rx_ready`, `rx_overrun`, `stop_gen` and `nack_pend` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_rise | input | 1 | Strobe: SCL rising edge (SDA sample point) |
| scl_fall | input | 1 | Strobe: SCL falling edge |
| sda_in | input | 1 | Synchronised SDA level |
| ctrl_we | input | 1 | Control word write enable |
| ctrl_wdata | input | 6 | Control word |
| cnt_we | input | 1 | Byte counter load enable |
| cnt_wdata | input | CNT_W | Byte counter load value |
| rx_rd | input | 1 | Received byte consumed |
| sda_pull_en | output | 1 | Drive SDA low |
| byte_stb | output | 1 | One-cycle pulse on an accepted byte |
| rx_byte | output | 8 | Last accepted byte |
| rx_ready | output | 1 | Unread byte present |
| rx_overrun | output | 1 | Byte lost to overrun |
| stop_gen | output | 1 | One-cycle STOP condition request |
| nack_pend | output | 1 | NACK request still pending |

## Verification
A wrong bit position shows up as a corrupted `rx_byte` or a misplaced `byte_stb` on the very byte where it happens, because the strobe timing is fixed to the eighth rising strobe. A wrong ACK decision or counter value shows up in the next acknowledge clock as `sda_pull_en` at the wrong level, and a misplaced `stop_gen` shows up one byte early or late. The bench therefore sweeps every byte value, every NACK-request write position and every counter load of a narrow counter. It compares the ACK level and the STOP pulse on each byte against values computed arithmetically.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  typedef enum logic [1:0] {
    PH_DATA = 2'd0,
    PH_WAIT = 2'd1,
    PH_ACK  = 2'd2
  } phase_t;

  // Control word; member order sets the bit positions (bit 0 = run)
  typedef struct packed {
    logic nack_req;
    logic xfer_en;
    logic stop_req;
    logic repeat_md;
    logic master;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/rxa_shift.sv
module rxa_shift
  import rxa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_in,
  input  logic       ack_ok,
  output logic       byte_done,
  output logic       ack_end,
  output logic       sda_pull_en,
  output logic [7:0] byte_val
);

  phase_t     ph_q, ph_d;
  logic [2:0] idx_q, idx_d;
  logic [6:0] sh_q, sh_d;
  logic       pull_d;

  always_comb begin
    ph_d      = ph_q;
    idx_d     = idx_q;
    sh_d      = sh_q;
    pull_d    = sda_pull_en;
    byte_done = 1'b0;
    ack_end   = 1'b0;
    if (abort) begin
      ph_d   = PH_DATA;
      idx_d  = '0;
      sh_d   = '0;
      pull_d = 1'b0;
    end else begin
      case (ph_q)
        PH_DATA: if (scl_rise) begin
          sh_d  = {sh_q[5:0], sda_in};
          idx_d = idx_q + 3'd1;
          if (idx_q == 3'd7) begin
            byte_done = 1'b1;
            ph_d      = PH_WAIT;
          end
        end
        PH_WAIT: if (scl_fall) begin
          ph_d   = PH_ACK;
          pull_d = ack_ok;
        end
        PH_ACK: if (scl_fall) begin
          ph_d    = PH_DATA;
          pull_d  = 1'b0;
          ack_end = 1'b1;
        end
        default: ph_d = PH_DATA;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_DATA;
      idx_q       <= '0;
      sh_q        <= '0;
      sda_pull_en <= 1'b0;
    end else begin
      ph_q        <= ph_d;
      idx_q       <= idx_d;
      sh_q        <= sh_d;
      sda_pull_en <= pull_d;
    end
  end

  assign byte_val = {sh_q, sda_in};

  AST_PULL_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_en) |-> $past(scl_fall) && $past(ack_ok)); // R2

endmodule

// File: rtl/rxa_ctrl.sv
module rxa_ctrl
  import rxa_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [5:0]       ctrl_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             byte_done,
  input  logic             ack_end,
  input  logic             ovr_hit,
  output logic             abort,
  output logic             ack_ok,
  output logic             stop_gen,
  output logic             nack_pend,
  output logic             master_md
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  ctrl_t            wr_c, ctl_q, ctl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             late_q, late_d, start_q, start_d, end_q, end_d;
  logic             ack_d, stop_d, last_byte, want_nack;

  assign wr_c      = ctrl_t'(ctrl_wdata);
  assign abort     = ~ctl_q.run | (ctrl_we & ~wr_c.run);
  assign last_byte = ctl_q.master & ctl_q.stop_req &
                     (ctl_q.repeat_md | (cnt_q == CNT_ONE) | late_q);
  assign want_nack = ctl_q.nack_req | last_byte |
                     (~ctl_q.master & (ovr_hit | ~ctl_q.xfer_en));

  always_comb begin
    ctl_d   = ctl_q;
    cnt_d   = cnt_q;
    late_d  = late_q;
    start_d = start_q;
    end_d   = end_q;
    ack_d   = ack_ok;
    stop_d  = 1'b0;
    if (byte_done && !abort) begin
      ack_d   = ~want_nack;
      end_d   = last_byte;
      start_d = 1'b1;
      ctl_d.nack_req = 1'b0;
      if (ctl_q.master && !ctl_q.repeat_md) cnt_d = cnt_q - CNT_ONE;
    end
    if (ack_end && !abort) begin
      stop_d = end_q;
      if (end_q) begin
        ctl_d.stop_req = 1'b0;
        late_d  = 1'b0;
        start_d = 1'b0;
        end_d   = 1'b0;
      end
    end
    if (ctrl_we) begin
      late_d = late_d | (wr_c.stop_req & ~ctl_q.stop_req & start_q);
      ctl_d  = wr_c;
    end
    if (cnt_we) cnt_d = cnt_wdata;
    if (abort) begin
      late_d  = 1'b0;
      start_d = 1'b0;
      end_d   = 1'b0;
      ack_d   = 1'b0;
      stop_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      cnt_q    <= '0;
      late_q   <= 1'b0;
      start_q  <= 1'b0;
      end_q    <= 1'b0;
      ack_ok   <= 1'b0;
      stop_gen <= 1'b0;
    end else begin
      ctl_q    <= ctl_d;
      cnt_q    <= cnt_d;
      late_q   <= late_d;
      start_q  <= start_d;
      end_q    <= end_d;
      ack_ok   <= ack_d;
      stop_gen <= stop_d;
    end
  end

  assign nack_pend = ctl_q.nack_req;
  assign master_md = ctl_q.master;

  AST_STOP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    stop_gen |-> $past(ack_end)); // R6
  AST_NACK_REQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ctl_q.nack_req && !abort && !ctrl_we) |=> !nack_pend); // R3

endmodule

// File: rtl/rxa_rxbuf.sv
module rxa_rxbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       byte_done,
  input  logic [7:0] byte_val,
  input  logic       rx_rd,
  output logic       ovr_hit,
  output logic       byte_stb,
  output logic [7:0] rx_byte,
  output logic       rx_ready,
  output logic       rx_overrun
);

  logic [7:0] byte_d;
  logic       rdy_d, ovr_d, stb_d;

  assign ovr_hit = rx_ready & ~rx_rd;

  always_comb begin
    byte_d = rx_byte;
    rdy_d  = rx_ready;
    ovr_d  = rx_overrun;
    stb_d  = 1'b0;
    if (abort) begin
      byte_d = '0;
      rdy_d  = 1'b0;
      ovr_d  = 1'b0;
    end else begin
      if (rx_rd) begin
        rdy_d = 1'b0;
        ovr_d = 1'b0;
      end
      if (byte_done) begin
        if (ovr_hit) begin
          ovr_d = 1'b1;
        end else begin
          byte_d = byte_val;
          rdy_d  = 1'b1;
          stb_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte    <= '0;
      rx_ready   <= 1'b0;
      rx_overrun <= 1'b0;
      byte_stb   <= 1'b0;
    end else begin
      rx_byte    <= byte_d;
      rx_ready   <= rdy_d;
      rx_overrun <= ovr_d;
      byte_stb   <= stb_d;
    end
  end

  AST_STB_MEANS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> rx_ready); // R1
  AST_OVR_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $stable(rx_byte)); // R4

endmodule

// File: rtl/rx_ack_engine.sv
module rx_ack_engine #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_in,
  input  logic             ctrl_we,
  input  logic [5:0]       ctrl_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             rx_rd,
  output logic             sda_pull_en,
  output logic             byte_stb,
  output logic [7:0]       rx_byte,
  output logic             rx_ready,
  output logic             rx_overrun,
  output logic             stop_gen,
  output logic             nack_pend
);

  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       abort, ack_ok, byte_done, ack_end, ovr_hit, master_md;
  logic [7:0] byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  rxa_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_s),
    .abort      (abort),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_in     (sda_in),
    .ack_ok     (ack_ok),
    .byte_done  (byte_done),
    .ack_end    (ack_end),
    .sda_pull_en(sda_pull_en),
    .byte_val   (byte_val)
  );

  rxa_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .ctrl_we   (ctrl_we),
    .ctrl_wdata(ctrl_wdata),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .byte_done (byte_done),
    .ack_end   (ack_end),
    .ovr_hit   (ovr_hit),
    .abort     (abort),
    .ack_ok    (ack_ok),
    .stop_gen  (stop_gen),
    .nack_pend (nack_pend),
    .master_md (master_md)
  );

  rxa_rxbuf u_rxbuf (
    .clk       (clk),
    .rst_n     (rst_s),
    .abort     (abort),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .rx_rd     (rx_rd),
    .ovr_hit   (ovr_hit),
    .byte_stb  (byte_stb),
    .rx_byte   (rx_byte),
    .rx_ready  (rx_ready),
    .rx_overrun(rx_overrun)
  );

  AST_NACK_REQ_HONOURED: assert property (@(posedge clk) disable iff (!rst_s)
    (byte_done && nack_pend && !abort) |=> !ack_ok); // R3
  AST_SLAVE_OVR_NACK: assert property (@(posedge clk) disable iff (!rst_s)
    (byte_done && ovr_hit && !master_md && !abort) |=> !ack_ok); // R4
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_s)
    abort |=> (!sda_pull_en && !rx_ready && !rx_overrun)); // R9

endmodule

// File: tb/rx_ack_engine_tb_top.sv
`timescale 1ns/1ps
module rx_ack_engine_tb_top;

  localparam int CW = 4;
  localparam logic [5:0] SLV  = 6'b010001;
  localparam logic [5:0] MREP = 6'b010111;
  localparam logic [5:0] MNR  = 6'b010011;
  localparam logic [5:0] STP  = 6'b001000;
  localparam logic [5:0] NAK  = 6'b100000;

  logic clk, rst_n, scl_rise, scl_fall, sda_in, ctrl_we, cnt_we, rx_rd;
  logic [5:0] ctrl_wdata;
  logic [CW-1:0] cnt_wdata;
  logic sda_pull_en, byte_stb, rx_ready, rx_overrun, stop_gen, nack_pend;
  logic [7:0] rx_byte;
  logic auto_rd, done;
  int n_vec, n_err;

  rx_ack_engine #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_in(sda_in), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .rx_rd(rx_rd),
    .sda_pull_en(sda_pull_en), .byte_stb(byte_stb), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun), .stop_gen(stop_gen),
    .nack_pend(nack_pend)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [5:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic cnt_write(input logic [CW-1:0] v);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic p_rise(input logic b);
    @(negedge clk); scl_rise = 1'b1; sda_in = b;
    @(negedge clk); scl_rise = 1'b0;
  endtask

  task automatic p_fall();
    @(negedge clk); scl_fall = 1'b1;
    @(negedge clk); scl_fall = 1'b0;
  endtask

  task automatic cfg(input logic [5:0] v);
    ctrl_write(6'h00);
    ctrl_write(v);
  endtask

  // wr_pos k: control write after k data bits (8 = after the decision edge)
  task automatic send_byte(input logic [7:0] d, input int wr_pos, input logic [5:0] wr_val,
                           output logic stb, output logic ack, output logic stp);
    for (int i = 0; i < 8; i++) begin
      if (wr_pos == i) ctrl_write(wr_val);
      p_rise(d[7-i]);
    end
    stb = byte_stb;
    if (sda_pull_en !== 1'b0) chk("R2 pull during data", 32'(sda_pull_en), 0);
    if (wr_pos == 8) ctrl_write(wr_val);
    p_fall();
    ack = sda_pull_en;
    p_rise(1'b0);
    p_fall();
    stp = stop_gen;
    if (sda_pull_en !== 1'b0) chk("R2 release after ack", 32'(sda_pull_en), 0);
    if (auto_rd) rd_pulse();
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic s, a, p;
    n_vec = 0; n_err = 0; auto_rd = 1'b1;
    rst_n = 1'b0; scl_rise = 0; scl_fall = 0; sda_in = 0; ctrl_we = 0;
    ctrl_wdata = '0; cnt_we = 0; cnt_wdata = '0; rx_rd = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 pull", 32'(sda_pull_en), 0);
    chk("R10 stb", 32'(byte_stb), 0);
    chk("R10 ready", 32'(rx_ready), 0);
    chk("R10 overrun", 32'(rx_overrun), 0);
    chk("R10 stop", 32'(stop_gen), 0);
    chk("R10 nack_pend", 32'(nack_pend), 0);

    // R1, R2: every byte value, slave, ACK expected
    cfg(SLV);
    for (int v = 0; v < 256; v++) begin
      auto_rd = 1'b0;
      send_byte(8'(v), -1, '0, s, a, p);
      chk("R1 strobe", 32'(s), 1);
      chk("R1 data", 32'(rx_byte), 32'(v));
      chk("R1 ready", 32'(rx_ready), 1);
      chk("R2 ack", 32'(a), 1);
      rd_pulse();
      chk("R1 read clears ready", 32'(rx_ready), 0);
    end
    auto_rd = 1'b1;

    // R3: NACK request at each write position
    for (int k = 0; k <= 8; k++) begin
      cfg(SLV);
      send_byte(8'h5A, k, SLV | NAK, s, a, p);
      if (k < 8) begin
        chk("R3 early nack", 32'(a), 0);
        chk("R3 pend cleared", 32'(nack_pend), 0);
        send_byte(8'h5B, -1, '0, s, a, p);
        chk("R3 following ack", 32'(a), 1);
      end else begin
        chk("R3 late still ack", 32'(a), 1);
        chk("R3 late pend", 32'(nack_pend), 1);
        send_byte(8'h5B, -1, '0, s, a, p);
        chk("R3 next nack", 32'(a), 0);
        chk("R3 pend cleared", 32'(nack_pend), 0);
      end
    end

    // R4: slave overrun
    cfg(SLV); auto_rd = 1'b0;
    send_byte(8'hC3, -1, '0, s, a, p);
    chk("R4 first ack", 32'(a), 1);
    send_byte(8'h3C, -1, '0, s, a, p);
    chk("R4 ovr nack", 32'(a), 0);
    chk("R4 no strobe", 32'(s), 0);
    chk("R4 overrun flag", 32'(rx_overrun), 1);
    chk("R4 byte kept", 32'(rx_byte), 32'hC3);
    rd_pulse();
    chk("R4 overrun clear", 32'(rx_overrun), 0);
    // R4: master overrun still ACKed
    cfg(MREP);
    send_byte(8'h11, -1, '0, s, a, p);
    send_byte(8'h22, -1, '0, s, a, p);
    chk("R4 master ovr ack", 32'(a), 1);
    auto_rd = 1'b1;

    // R5: slave with transfers disabled
    cfg(6'b000001);
    for (int j = 0; j < 3; j++) begin
      send_byte(8'(j * 37), -1, '0, s, a, p);
      chk("R5 disabled nack", 32'(a), 0);
    end

    // R6: repeat master mode
    cfg(MREP);
    for (int j = 0; j < 5; j++) begin
      send_byte(8'(j), -1, '0, s, a, p);
      chk("R6 repeat ack", 32'(a), 1);
      chk("R6 no stop", 32'(p), 0);
    end
    send_byte(8'h77, 4, MREP | STP, s, a, p);
    chk("R6 stop nack", 32'(a), 0);
    chk("R6 stop pulse", 32'(p), 1);
    send_byte(8'h78, -1, '0, s, a, p);
    chk("R6 stop cleared", 32'(p), 0);
    chk("R6 ack after stop", 32'(a), 1);

    // R7: counter sweep, 0 means 2^CW
    for (int n = 0; n < (1 << CW); n++) begin
      int exp_n;
      exp_n = (n == 0) ? (1 << CW) : n;
      cfg(MNR | STP);
      cnt_write(CW'(n));
      for (int j = 1; j <= exp_n; j++) begin
        send_byte(8'(j), -1, '0, s, a, p);
        chk("R7 count ack", 32'(a), 32'(j != exp_n));
        chk("R7 count stop", 32'(p), 32'(j == exp_n));
      end
    end

    // R8: late STOP in non-repeat mode
    cfg(MNR);
    cnt_write(CW'(2));
    for (int j = 0; j < 4; j++) begin
      send_byte(8'hA0, -1, '0, s, a, p);
      chk("R8 no stop without request", 32'(p), 0);
    end
    send_byte(8'hA1, 3, MNR | STP, s, a, p);
    chk("R8 late nack", 32'(a), 0);
    chk("R8 late stop", 32'(p), 1);

    // R9: abort during ack clock and mid-byte
    cfg(SLV);
    for (int i = 0; i < 8; i++) p_rise(1'(8'hA5 >> (7 - i)));
    p_fall();
    chk("R9 pulled before abort", 32'(sda_pull_en), 1);
    ctrl_write(6'h00);
    chk("R9 released", 32'(sda_pull_en), 0);
    chk("R9 ready cleared", 32'(rx_ready), 0);
    ctrl_write(SLV);
    p_rise(1'b1); p_rise(1'b1); p_rise(1'b0);
    ctrl_write(6'h00);
    ctrl_write(SLV);
    send_byte(8'h3C, -1, '0, s, a, p);
    chk("R9 fresh byte", 32'(rx_byte), 32'h3C);
    chk("R9 fresh ack", 32'(a), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule